// File: doc/BRIEF.md
# Stop-Clock Power State Sequencer

This controller sits inside a processor core and turns an active-low request for clock stopping into an orderly shutdown of the internal clock. The request can come from any clock domain. It first passes through a synchronizer chain. The block then waits for the core to report an instruction boundary before it commits. Once committed, it walks a fixed handshake: it asks the pipeline to flush, waits for outstanding bus traffic to finish, and raises a request for the acknowledge special bus cycle. After the bus answers that cycle with ready, and the write buffer reports empty (unless that condition is masked), it drops the internal clock enable. That point is the stop-grant state.

While stop-grant holds, system logic may halt the bus clock, and the sequencer records this as a deeper stop-clock state. When the requester lets go, the block returns to normal run. If the bus clock is halted at that time, the block waits until the bus clock runs again, passes back through stop-grant, and only then re-enables the internal clock. The current state is driven out on a status port.

Top module: `stpc_seq`

## Requirements
- R1: After reset, `state_o` reads RUN (code 0), `clk_en` is 1, and `flush_req` and `sg_req` are 0. State codes: RUN=0, WAIT_BOUNDARY=1, FLUSH=2, DRAIN=3, SPECIAL=4, WAIT_WB=5, STOP_GRANT=6, STOP_CLOCK=7.
- R2: `stop_req_n` goes through a chain of SYNC_STAGES flops (default 2). With the default, a low level first driven between two rising edges leaves `state_o` at RUN for the next two rising edges. It reads WAIT_BOUNDARY after the third rising edge.
- R3: The block leaves WAIT_BOUNDARY for FLUSH only on a rising edge where `insn_boundary` is 1. If the synchronized request drops while in WAIT_BOUNDARY, the block returns to RUN and never raises `flush_req` or `sg_req`.
- R4: `flush_req` is 1 exactly while in FLUSH. The block moves to DRAIN on the first edge at which `flush_done` is 1.
- R5: The block stays in DRAIN while `bus_pending` is 1, and moves to SPECIAL on the first edge at which it is 0.
- R6: `sg_req` rises in SPECIAL and stays 1 until `sg_ready` is sampled 1, and then the block moves to WAIT_WB. `sg_req` rises exactly once per entry.
- R7: In WAIT_WB, `clk_en` stays 1 until `wb_empty` is 1 or `wb_mask` is 1. On that edge the block enters STOP_GRANT and `clk_en` drops to 0. When `wb_mask` is 1, a low `wb_empty` does not delay entry.
- R8: STOP_GRANT moves to STOP_CLOCK while `busclk_stopped` is 1. STOP_CLOCK returns to STOP_GRANT when `busclk_stopped` is 0. A request release in STOP_CLOCK neither changes the state nor raises `clk_en`.
- R9: In STOP_GRANT, a synchronized release moves the block to RUN on the next edge, with `clk_en` back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req_n | input | 1 | Active-low stop request, may be asynchronous |
| insn_boundary | input | 1 | Strobe: the core is at an instruction boundary |
| flush_req | output | 1 | Pipeline flush request |
| flush_done | input | 1 | Pipeline flush complete |
| bus_pending | input | 1 | Bus cycles pending or in progress |
| sg_req | output | 1 | Request for the stop-grant special bus cycle |
| sg_ready | input | 1 | Ready for the special bus cycle |
| wb_empty | input | 1 | Write buffer empty |
| wb_mask | input | 1 | 1 = ignore write-buffer-empty |
| busclk_stopped | input | 1 | System has halted the bus clock |
| clk_en | output | 1 | Internal clock enable |
| state_o | output | 3 | Current sequencer state code |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and the write-buffer qualifier present. The two-stage depth makes the three-edge recognition latency exact and checkable. Keeping the qualifier built in lets both the held-off entry and the masked entry be exercised on the same instance.

// File: rtl/stpc_pkg.sv
package stpc_pkg;
   localparam int ST_W = 3;
   typedef enum logic [ST_W-1:0] {
      ST_RUN        = 3'd0,
      ST_WAIT_BND   = 3'd1,
      ST_FLUSH      = 3'd2,
      ST_DRAIN      = 3'd3,
      ST_SPECIAL    = 3'd4,
      ST_WAIT_WB    = 3'd5,
      ST_STOP_GRANT = 3'd6,
      ST_STOP_CLOCK = 3'd7
   } stpc_state_t;
endpackage

// File: rtl/stpc_sync.sv
module stpc_sync #(
   parameter int STAGES   = 2,
   parameter bit RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_depth
      $error("stpc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= RST_VAL;
         end else begin
            if (i == 0) begin
               chain[i] <= d_in;
            end else begin
               chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
         end
      end
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/stpc_wbq.sv
module stpc_wbq #(
   parameter bit HONOR_WB = 1'b1
) (
   input  logic wb_empty,
   input  logic wb_mask,
   output logic wb_ok
);
   if (HONOR_WB) begin : g_honor
      assign wb_ok = wb_empty | wb_mask;
   end else begin : g_ignore
      logic unused_in;
      assign unused_in = wb_empty ^ wb_mask;
      assign wb_ok = 1'b1;
   end
endmodule

// File: rtl/stpc_fsm.sv
module stpc_fsm
   import stpc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        insn_boundary,
   input  logic        flush_done,
   input  logic        bus_pending,
   input  logic        sg_ready,
   input  logic        wb_ok,
   input  logic        busclk_stopped,
   output stpc_state_t state
);
   stpc_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN:        if (req) nxt = ST_WAIT_BND;
         ST_WAIT_BND: begin
            if (!req)               nxt = ST_RUN;
            else if (insn_boundary) nxt = ST_FLUSH;
         end
         ST_FLUSH:      if (flush_done) nxt = ST_DRAIN;
         ST_DRAIN:      if (!bus_pending) nxt = ST_SPECIAL;
         ST_SPECIAL:    if (sg_ready) nxt = ST_WAIT_WB;
         ST_WAIT_WB:    if (wb_ok) nxt = ST_STOP_GRANT;
         ST_STOP_GRANT: begin
            if (!req)                nxt = ST_RUN;
            else if (busclk_stopped) nxt = ST_STOP_CLOCK;
         end
         ST_STOP_CLOCK: if (!busclk_stopped) nxt = ST_STOP_GRANT;
         default:       nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= nxt;
   end
endmodule

// File: rtl/stpc_seq.sv
module stpc_seq
   import stpc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HONOR_WB    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stop_req_n,
   input  logic            insn_boundary,
   output logic            flush_req,
   input  logic            flush_done,
   input  logic            bus_pending,
   output logic            sg_req,
   input  logic            sg_ready,
   input  logic            wb_empty,
   input  logic            wb_mask,
   input  logic            busclk_stopped,
   output logic            clk_en,
   output logic [ST_W-1:0] state_o
);
   logic        req_n_sync;
   logic        req;
   logic        wb_ok;
   stpc_state_t state;

   stpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (stop_req_n),
      .q_out (req_n_sync)
   );

   assign req = ~req_n_sync;

   stpc_wbq #(.HONOR_WB(HONOR_WB)) u_wbq (
      .wb_empty (wb_empty),
      .wb_mask  (wb_mask),
      .wb_ok    (wb_ok)
   );

   stpc_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req            (req),
      .insn_boundary  (insn_boundary),
      .flush_done     (flush_done),
      .bus_pending    (bus_pending),
      .sg_ready       (sg_ready),
      .wb_ok          (wb_ok),
      .busclk_stopped (busclk_stopped),
      .state          (state)
   );

   assign flush_req = (state == ST_FLUSH);
   assign sg_req    = (state == ST_SPECIAL);
   assign clk_en    = !((state == ST_STOP_GRANT) || (state == ST_STOP_CLOCK));
   assign state_o   = state;
endmodule

// File: rtl/stpc_seq_chk.sv
module stpc_seq_chk
   import stpc_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            insn_boundary,
   input logic            flush_done,
   input logic            bus_pending,
   input logic            sg_req,
   input logic            sg_ready,
   input logic            wb_empty,
   input logic            wb_mask,
   input logic            busclk_stopped,
   input logic            clk_en,
   input logic [ST_W-1:0] state_o
);
   AST_BOUNDARY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_FLUSH && $past(state_o) == ST_WAIT_BND) |-> $past(insn_boundary)); // R3

   AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_FLUSH && !flush_done) |=> (state_o == ST_FLUSH)); // R4

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_DRAIN && bus_pending) |=> (state_o == ST_DRAIN)); // R5

   AST_SPECIAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sg_req && !sg_ready) |=> sg_req); // R6

   AST_GATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> ($past(state_o) == ST_WAIT_WB && ($past(wb_empty) || $past(wb_mask)))); // R7

   AST_STOPCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_STOP_CLOCK && busclk_stopped) |=> (state_o == ST_STOP_CLOCK && !clk_en)); // R8
endmodule

bind stpc_seq stpc_seq_chk u_chk (.*);

// File: tb/stpc_seq_test.sv
module stpc_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req_n = 1'b1;
   logic       insn_boundary = 1'b0;
   logic       flush_done = 1'b0;
   logic       bus_pending = 1'b0;
   logic       sg_ready = 1'b0;
   logic       wb_empty = 1'b0;
   logic       wb_mask = 1'b0;
   logic       busclk_stopped = 1'b0;
   logic       flush_req, sg_req, clk_en;
   logic [2:0] state_o;

   localparam logic [2:0] S_RUN = 3'd0, S_WB = 3'd1, S_FL = 3'd2, S_DR = 3'd3,
                          S_SP = 3'd4, S_WW = 3'd5, S_SG = 3'd6, S_SC = 3'd7;

   int n_cmp = 0;
   int n_bad = 0;
   int sg_rises = 0;
   int flush_cycles = 0;
   bit done = 1'b0;
   logic [2:0] exp_q[$];
   logic [2:0] prev_state = 3'd0;
   logic       prev_sg = 1'b0;

   stpc_seq uut (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .insn_boundary(insn_boundary),
      .flush_req(flush_req), .flush_done(flush_done), .bus_pending(bus_pending),
      .sg_req(sg_req), .sg_ready(sg_ready), .wb_empty(wb_empty), .wb_mask(wb_mask),
      .busclk_stopped(busclk_stopped), .clk_en(clk_en), .state_o(state_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: each state change pops the next expected state
   always @(negedge clk) begin
      if (rst_n) begin
         if (sg_req && !prev_sg) sg_rises++;
         if (flush_req) flush_cycles++;
         if (state_o != prev_state) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "SEQ unexpected transition", int'(state_o), int'(prev_state));
            end else begin
               logic [2:0] e;
               e = exp_q.pop_front();
               chk(state_o == e, "SEQ state order", int'(state_o), int'(e));
            end
         end
         prev_state = state_o;
         prev_sg = sg_req;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enter(input bit mask, input int pend, input int wb_hold);
      int rises0;
      rises0 = sg_rises;
      wb_mask = mask;
      wb_empty = 1'b0;
      exp_q.push_back(S_WB);
      stop_req_n = 1'b0;
      tick(2);
      chk(state_o == S_RUN, "R2 still RUN after two edges", int'(state_o), S_RUN);
      tick(1);
      chk(state_o == S_WB, "R2 WAIT_BOUNDARY after third edge", int'(state_o), S_WB);
      tick(3);
      chk(state_o == S_WB, "R3 waits for boundary", int'(state_o), S_WB);
      exp_q.push_back(S_FL);
      insn_boundary = 1'b1;
      tick(1);
      insn_boundary = 1'b0;
      chk(flush_req == 1'b1, "R4 flush_req in FLUSH", int'(flush_req), 1);
      tick(2);
      chk(state_o == S_FL, "R4 FLUSH held without done", int'(state_o), S_FL);
      exp_q.push_back(S_DR);
      bus_pending = 1'b1;
      flush_done = 1'b1;
      tick(1);
      flush_done = 1'b0;
      chk(flush_req == 1'b0, "R4 flush_req low after FLUSH", int'(flush_req), 0);
      tick(pend);
      chk(state_o == S_DR, "R5 DRAIN held while pending", int'(state_o), S_DR);
      exp_q.push_back(S_SP);
      bus_pending = 1'b0;
      tick(1);
      tick(3);
      chk(sg_req == 1'b1, "R6 sg_req held until ready", int'(sg_req), 1);
      exp_q.push_back(S_WW);
      sg_ready = 1'b1;
      tick(1);
      sg_ready = 1'b0;
      chk(sg_req == 1'b0, "R6 sg_req released after ready", int'(sg_req), 0);
      if (!mask) begin
         tick(wb_hold);
         chk(clk_en == 1'b1 && state_o == S_WW, "R7 clk_en held until wb empty",
             int'(clk_en), 1);
         exp_q.push_back(S_SG);
         wb_empty = 1'b1;
         tick(1);
      end else begin
         exp_q.push_back(S_SG);
         tick(1);
      end
      chk(state_o == S_SG, "R7 STOP_GRANT reached", int'(state_o), S_SG);
      chk(clk_en == 1'b0, "R7 clk_en low in STOP_GRANT", int'(clk_en), 0);
      chk(sg_rises - rises0 == 1, "R6 one special cycle per entry", sg_rises - rises0, 1);
   endtask

   initial begin
      tick(3);
      chk(state_o == S_RUN, "R1 reset state", int'(state_o), S_RUN);
      chk(clk_en == 1'b1, "R1 clk_en at reset", int'(clk_en), 1);
      chk(flush_req == 1'b0 && sg_req == 1'b0, "R1 requests idle at reset",
          int'({flush_req, sg_req}), 0);
      rst_n = 1'b1;
      tick(2);

      // full entry honoring write buffer, then release
      enter(1'b0, 4, 5);
      exp_q.push_back(S_RUN);
      stop_req_n = 1'b1;
      tick(2);
      chk(state_o == S_SG, "R9 still STOP_GRANT during sync", int'(state_o), S_SG);
      tick(1);
      chk(state_o == S_RUN && clk_en == 1'b1, "R9 back to RUN with clk_en", int'(state_o), S_RUN);
      tick(3);

      // discarded request without a boundary
      begin
         int r0, f0;
         r0 = sg_rises;
         f0 = flush_cycles;
         exp_q.push_back(S_WB);
         exp_q.push_back(S_RUN);
         stop_req_n = 1'b0;
         tick(6);
         stop_req_n = 1'b1;
         tick(6);
         chk(state_o == S_RUN, "R3 released request back to RUN", int'(state_o), S_RUN);
         chk(sg_rises == r0 && flush_cycles == f0, "R3 no flush or special on discard",
             sg_rises - r0 + flush_cycles - f0, 0);
      end

      // masked write buffer, then stop-clock path
      enter(1'b1, 1, 0);
      exp_q.push_back(S_SC);
      busclk_stopped = 1'b1;
      tick(2);
      chk(state_o == S_SC, "R8 STOP_CLOCK entered", int'(state_o), S_SC);
      stop_req_n = 1'b1;
      tick(6);
      chk(state_o == S_SC && clk_en == 1'b0, "R8 release ignored in STOP_CLOCK",
          int'(state_o), S_SC);
      exp_q.push_back(S_SG);
      exp_q.push_back(S_RUN);
      busclk_stopped = 1'b0;
      tick(1);
      chk(state_o == S_SG, "R8 back to STOP_GRANT", int'(state_o), S_SG);
      tick(1);
      chk(state_o == S_RUN && clk_en == 1'b1, "R9 RUN after STOP_GRANT", int'(state_o), S_RUN);
      tick(3);
      chk(exp_q.size() == 0, "SEQ all expected transitions seen", exp_q.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule